// File: doc/BRIEF.md
# Byte-Serial Accumulator Access Port

This block holds the 40-bit running accumulator of a small math accelerator and exposes it to a processor through a single 8-bit register location. Whenever the arithmetic unit reports a finished multiply or divide, the reported 40-bit value is added into the accumulator. Results of shift or normalize operations are reported too, but they are not summed.

Software reaches the 40 bits one byte at a time. There are two independent byte pointers. The read pointer starts at the top byte and steps downward. The write pointer starts at the bottom byte and steps upward. Both pointers stop at their last byte and do not wrap. Both go back to their start positions when a result is reported, when the accumulator is cleared, or when the pointer-reset control is pulsed. A shorter value can be loaded with fewer writes. Any bytes that are not written keep their old contents.

Top module: `acc_byte_port`

## Requirements
- R1: After reset, the accumulator is zero, the read pointer selects byte 4 (bits 39:32) and the write pointer selects byte 0 (bits 7:0).
- R2: A `resValid` pulse with `resIsShift` low adds `resValue` to the accumulator on that clock edge. The sum wraps modulo 2^40.
- R3: A `resValid` pulse with `resIsShift` high leaves the accumulator unchanged.
- R4: `rdData` shows, combinationally, the byte that the read pointer selects. Each `rdEn` cycle moves the pointer down one byte, so five reads return bytes 4, 3, 2, 1, 0 in that order.
- R5: The read pointer stops at byte 0. Further reads keep returning bits 7:0.
- R6: Reads never change the accumulator.
- R7: Each `wrEn` cycle replaces only the byte the write pointer selects, then moves the pointer up one byte. The pointer stops at byte 4, so further writes overwrite bits 39:32. Writing 00h five times from the start position yields zero.
- R8: `resValid` (of either kind), `clrAcc` and `ptrRst` each return the read pointer to byte 4 and the write pointer to byte 0. This takes priority over a pointer step in the same cycle.
- R9: `clrAcc` sets the accumulator to zero. It overrides an accumulate or a write in the same cycle.
- R10: A byte write in the same cycle as `resValid` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous system reset |
| rdEn | input | 1 | Byte read access in this cycle |
| wrEn | input | 1 | Byte write access in this cycle |
| wrData | input | 8 | Byte to be written |
| rdData | output | 8 | Byte selected by the read pointer |
| resValid | input | 1 | Arithmetic result reported this cycle |
| resIsShift | input | 1 | Reported result comes from a shift or normalize |
| resValue | input | 40 | Reported result value |
| clrAcc | input | 1 | Clear the accumulator and home both pointers |
| ptrRst | input | 1 | Home both pointers |
| accValue | output | 40 | Current accumulator contents |

## Verification
Write sequences use a distinct value in every byte. This shows whether a lane was misplaced, whether the pointer saturated, and whether a sixth write went to the top byte. Reads compare the full top-to-bottom order and then read past the end. Results are sent in several forms: a plain add, an add whose carry crosses every byte, a shift result, and results that arrive together with a write or a clear. These separate the accumulate gating, the modulo wrap and the priority order. Each pointer-homing event is followed by a read and a write, which shows that both pointers moved back.

// File: rtl/accport_pkg.sv
package accport_pkg;

  // Strobes from pointer control to the accumulator datapath
  typedef struct packed {
    logic doClear;   // zero the accumulator
    logic doAccum;   // add reported result
    logic doWrite;   // replace the selected byte
  } accStrobes_t;

endpackage

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import accport_pkg::*;
#(
  parameter int NUM_BYTES = 5,
  localparam int PTR_W = $clog2(NUM_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdEn,
  input  logic             wrEn,
  input  logic             resValid,
  input  logic             resIsShift,
  input  logic             clrAcc,
  input  logic             ptrRst,
  output accStrobes_t      strobes,
  output logic [PTR_W-1:0] rdPtr,
  output logic [PTR_W-1:0] wrPtr
);

  localparam logic [PTR_W-1:0] TOP_IDX = PTR_W'(NUM_BYTES - 1);
  localparam logic [PTR_W-1:0] BOT_IDX = '0;

  logic ptrHome;
  logic rdStep;
  logic wrStep;

  always_comb begin
    ptrHome         = resValid | clrAcc | ptrRst;
    strobes.doClear = clrAcc;
    strobes.doAccum = resValid & ~resIsShift & ~clrAcc;
    strobes.doWrite = wrEn & ~resValid & ~clrAcc;
    rdStep          = rdEn & ~ptrHome & (rdPtr != BOT_IDX);
    wrStep          = strobes.doWrite & ~ptrHome & (wrPtr != TOP_IDX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= TOP_IDX;
      wrPtr <= BOT_IDX;
    end else if (ptrHome) begin
      rdPtr <= TOP_IDX;
      wrPtr <= BOT_IDX;
    end else begin
      if (rdStep) rdPtr <= rdPtr - 1'b1;
      if (wrStep) wrPtr <= wrPtr + 1'b1;
    end
  end

  // R8
  ptr_home_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid || clrAcc || ptrRst) |=> (rdPtr == TOP_IDX && wrPtr == BOT_IDX));

  // R5
  rd_ptr_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdPtr == BOT_IDX && rdEn) |=> (rdPtr == BOT_IDX || rdPtr == TOP_IDX));

  // R7
  wr_ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !resValid && !clrAcc && !ptrRst && wrPtr != TOP_IDX)
      |=> (wrPtr == $past(wrPtr) + 1'b1));

  // R4
  rd_ptr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdPtr <= TOP_IDX && wrPtr <= TOP_IDX));

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import accport_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 5,
  localparam int ACC_W = BYTE_W * NUM_BYTES,
  localparam int PTR_W = $clog2(NUM_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  accStrobes_t       strobes,
  input  logic [PTR_W-1:0]  rdSel,
  input  logic [PTR_W-1:0]  wrSel,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [ACC_W-1:0]  resValue,
  output logic [BYTE_W-1:0] rdData,
  output logic [ACC_W-1:0]  accValue
);

  logic [NUM_BYTES-1:0][BYTE_W-1:0] accR;
  logic [NUM_BYTES-1:0][BYTE_W-1:0] laneWr;
  logic [ACC_W-1:0]                 sumVal;
  logic [ACC_W-1:0]                 accNext;

  // per-lane byte replacement
  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    always_comb begin
      laneWr[g] = (strobes.doWrite && wrSel == PTR_W'(g)) ? wrData : accR[g];
    end
  end

  always_comb begin
    sumVal = accR + resValue;
    if (strobes.doClear)      accNext = '0;
    else if (strobes.doAccum) accNext = sumVal;
    else                      accNext = laneWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) accR <= '0;
    else       accR <= accNext;
  end

  always_comb begin
    rdData = (rdSel < PTR_W'(NUM_BYTES)) ? accR[rdSel] : '0;
  end

  assign accValue = accR;

  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doClear |=> (accValue == '0));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.doClear && !strobes.doAccum && !strobes.doWrite) |=> $stable(accValue));

endmodule

// File: rtl/acc_byte_port.sv
module acc_byte_port
  import accport_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 5,
  localparam int ACC_W = BYTE_W * NUM_BYTES,
  localparam int PTR_W = $clog2(NUM_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  input  logic              resValid,
  input  logic              resIsShift,
  input  logic [ACC_W-1:0]  resValue,
  input  logic              clrAcc,
  input  logic              ptrRst,
  output logic [ACC_W-1:0]  accValue
);

  accStrobes_t      strobes;
  logic [PTR_W-1:0] rdPtr;
  logic [PTR_W-1:0] wrPtr;

  acc_ctrl #(.NUM_BYTES(NUM_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn),
    .resValid(resValid), .resIsShift(resIsShift),
    .clrAcc(clrAcc), .ptrRst(ptrRst),
    .strobes(strobes), .rdPtr(rdPtr), .wrPtr(wrPtr)
  );

  acc_datapath #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .rdSel(rdPtr), .wrSel(wrPtr), .wrData(wrData),
    .resValue(resValue), .rdData(rdData), .accValue(accValue)
  );

  // R2
  accum_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resIsShift && !clrAcc)
      |=> (accValue == ($past(accValue) + $past(resValue))));

  // R3
  shift_no_acc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resIsShift && !clrAcc) |=> $stable(accValue));

  // R10
  write_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resIsShift && wrEn && !clrAcc) |=> $stable(accValue));

endmodule

// File: tb/acc_byte_port_tb.sv
module acc_byte_port_tb;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit          isAcc;
    logic [39:0] exp;
    string       req;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdEn = 1'b0, wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic        resValid = 1'b0, resIsShift = 1'b0;
  logic [39:0] resValue = '0;
  logic        clrAcc = 1'b0, ptrRst = 1'b0;
  logic [39:0] accValue;
  logic        chkAcc = 1'b0;

  int          total = 0, failed = 0;
  bit          finished = 1'b0;
  expItem_t    sbq[$];

  logic [39:0] mAcc = '0;
  int          mRd = 4, mWr = 0;

  acc_byte_port u_dut (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .resValid(resValid), .resIsShift(resIsShift),
    .resValue(resValue), .clrAcc(clrAcc), .ptrRst(ptrRst), .accValue(accValue)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: compares a quarter period after the driving edge
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (rdEn || chkAcc) begin
      expItem_t it;
      logic [39:0] act;
      total++;
      if (sbq.size() == 0) begin
        failed++;
        $display("FAIL scoreboard empty act=%h exp=none", rdEn ? {32'h0, rdData} : accValue);
      end else begin
        it = sbq.pop_front();
        act = it.isAcc ? accValue : {32'h0, rdData};
        if (act !== it.exp) begin
          failed++;
          $display("FAIL %s act=%h exp=%h", it.req, act, it.exp);
        end
      end
    end
  end

  function automatic void homePtrs();
    mRd = 4; mWr = 0;
  endfunction

  task automatic doRead(string req);
    sbq.push_back('{1'b0, {32'h0, mAcc[mRd*8 +: 8]}, req});
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    if (mRd > 0) mRd--;
  endtask

  task automatic doWrite(logic [7:0] b);
    wrEn = 1'b1; wrData = b;
    @(negedge clk);
    wrEn = 1'b0;
    mAcc[mWr*8 +: 8] = b;
    if (mWr < 4) mWr++;
  endtask

  task automatic doResult(logic [39:0] v, bit isShift, bit withWrite, bit withClr);
    resValid = 1'b1; resIsShift = isShift; resValue = v;
    wrEn = withWrite; wrData = 8'h77; clrAcc = withClr;
    @(negedge clk);
    resValid = 1'b0; resIsShift = 1'b0; wrEn = 1'b0; clrAcc = 1'b0;
    if (withClr) mAcc = '0;
    else if (!isShift) mAcc = mAcc + v;
    homePtrs();
  endtask

  task automatic doClear();
    clrAcc = 1'b1;
    @(negedge clk);
    clrAcc = 1'b0;
    mAcc = '0; homePtrs();
  endtask

  task automatic doPtrRst();
    ptrRst = 1'b1;
    @(negedge clk);
    ptrRst = 1'b0;
    homePtrs();
  endtask

  task automatic checkAcc(string req);
    sbq.push_back('{1'b1, mAcc, req});
    chkAcc = 1'b1;
    @(negedge clk);
    chkAcc = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    checkAcc("R1 reset accumulator");
    doRead("R1 reset read pointer at top byte");
    doPtrRst();

    // R7 LSB-first loading, saturation at top byte
    doWrite(8'h11); doWrite(8'h22); doWrite(8'h33); doWrite(8'h44); doWrite(8'h55);
    checkAcc("R7 five byte load");
    doWrite(8'h66);
    checkAcc("R7 sixth write hits top byte");

    // R4 / R5 / R6 read order and saturation
    for (int i = 0; i < 5; i++) doRead("R4 read order");
    doRead("R5 read saturates at byte 0");
    doRead("R5 read saturates at byte 0");
    checkAcc("R6 reads leave accumulator");

    // R8 pointer reset control
    doPtrRst();
    doRead("R8 ptrRst homes read pointer");
    doWrite(8'hAA);
    checkAcc("R8 ptrRst homes write pointer");

    // R2 accumulate, R8 result homes pointers
    doRead("R8 step before result");
    doResult(40'h00_0000_0100, 1'b0, 1'b0, 1'b0);
    checkAcc("R2 accumulate add");
    doRead("R8 result homes read pointer");
    doWrite(8'h5A);
    checkAcc("R8 result homes write pointer");

    // R3 shift result ignored
    doResult(40'h12_3456_789A, 1'b1, 1'b0, 1'b0);
    checkAcc("R3 shift result not summed");

    // R2 carry across all bytes and modulo wrap
    doClear();
    for (int i = 0; i < 5; i++) doWrite(8'hFF);
    doResult(40'h00_0000_0002, 1'b0, 1'b0, 1'b0);
    checkAcc("R2 modulo 2^40 wrap");
    doResult(40'h00_0000_00FF, 1'b0, 1'b0, 1'b0);
    checkAcc("R2 carry into byte 1");

    // R10 write dropped with result
    doResult(40'h00_0000_0010, 1'b0, 1'b1, 1'b0);
    checkAcc("R10 write dropped with accumulate");
    doResult(40'h00_0000_0010, 1'b1, 1'b1, 1'b0);
    checkAcc("R10 write dropped with shift result");

    // R9 clear over accumulate, clear homes pointers
    doRead("R9 step before clear");
    doRead("R9 step before clear");
    doResult(40'h01_0000_0000, 1'b0, 1'b0, 1'b1);
    checkAcc("R9 clear beats accumulate");
    doWrite(8'h3C); doWrite(8'hC3);
    doRead("R9 read after clear");
    doClear();
    checkAcc("R9 clear");
    doWrite(8'h01);
    checkAcc("R9 clear homes write pointer");

    // R7 partial 16-bit load keeps upper bytes
    doClear();
    for (int i = 0; i < 5; i++) doWrite(8'h9C);
    doPtrRst();
    doWrite(8'h12); doWrite(8'h34);
    checkAcc("R7 16-bit load keeps upper bytes");
    doPtrRst();
    for (int i = 0; i < 5; i++) doWrite(8'h00);
    checkAcc("R7 five zero writes give zero");

    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      finished = 1'b1;
      total++; failed++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

endmodule